// File: doc/BRIEF.md
# Radix-2 Single-Delay-Feedback FFT Butterfly Stage

This block is one decimation-in-frequency stage of a streaming FFT pipeline. It accepts one complex sample per cycle when its valid strobe is high and works on blocks of `V` samples. A feedback store of `V/2` complex entries holds the first half of each block. While the second half streams in, each arriving sample is paired with the stored sample `V/2` positions earlier. The stage emits their sum at once and writes their difference back into the store. While the first half of the following block streams in, the stage emits those stored differences in turn and refills the store with the new inputs.

Every result is `W_IN+1` bits wide. It is arithmetically shifted right by `TRUNC` bits and then clamped to a signed `W_OUT`-bit output. The real and imaginary lanes are identical and do not interact. When samples arrive back to back, the stage delay from a block's first input to its first output is `V/2 + 1` cycles. The package function `sdf_stage_delay` returns this value so that neighbouring stages can be aligned. Gaps in the valid strobe freeze the stage and do not disturb the sample order.

Top module: `sdf_bfly_r2`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and both output lanes are 0. The stage then starts at block position 0 with no stored differences.
- R2: For block position k = V/2 .. V-1, the output that follows is clamp(shift(x[k-V/2] + x[k])). The V/2 sums appear in increasing k.
- R3: For position k = 0 .. V/2-1 of the next block, the output is clamp(shift(x[k] - x[k+V/2])) of the previous block, in the same order as the sums. No difference is lost across consecutive blocks.
- R4: The real and imaginary lanes use the same operation, and neither lane's inputs affect the other lane's output.
- R5: The shift is arithmetic by `TRUNC` bits, which rounds toward minus infinity (with TRUNC=1, -9 becomes -5).
- R6: A shifted value above 2^(W_OUT-1)-1 is output as that maximum. A value below -2^(W_OUT-1) is output as that minimum. Sign is always preserved.
- R7: An output is registered: `out_valid` is high in the cycle after an accepted input that produces a result. With continuous input, the first result appears `sdf_stage_delay(V)` = V/2+1 cycles after the first sample.
- R8: A cycle with `in_valid` low leaves the block position and store unchanged. It is followed by a cycle with `out_valid` low and both output lanes unchanged.
- R9: The first half of the first block after reset produces no valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | W_IN | Real part, two's complement |
| in_im | input | W_IN | Imaginary part, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | W_OUT | Real result, shifted and clamped |
| out_im | output | W_OUT | Imaginary result, shifted and clamped |

## Verification
The bench streams several blocks through a small configuration (V=8, 8-bit in, 7-bit out, shift 1) and compares each output with an integer model of the sum-then-difference order:
- A ramp with unrelated real and imaginary patterns separates the lanes and shows whether pairing is off by a position.
- Negative odd sums distinguish a flooring shift from truncation toward zero.
- Blocks pinned near full scale, and blocks that alternate between the extremes, drive the sums and then the differences into both clamp limits.
- A block fed with an idle cycle after every sample shows that gaps neither advance the position nor disturb the held outputs.
- A final block flushes the last differences, and the measured delay to the first result is compared with the published stage delay.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    // Lane selector used to index the packed real/imaginary pairs.
    typedef enum int {
        LANE_RE = 0,
        LANE_IM = 1
    } sdf_lane_e;

    localparam int SDF_LANES = 2;

    // Cycles from a block's first input to its first output with an
    // uninterrupted valid strobe: half a block of fill plus the output register.
    function automatic int sdf_stage_delay(input int v);
        return v / 2 + 1;
    endfunction

endpackage

// File: rtl/sdf_seq_ctrl.sv
module sdf_seq_ctrl #(
    parameter int V = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   phase_hi,
    output logic [$clog2(V)-2:0]   rd_addr,
    output logic                   diff_ready
);
    localparam int CW = $clog2(V);
    localparam logic [CW-1:0] LAST = CW'(V - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (in_valid) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_hi   = s_q.cnt[CW-1];
    assign rd_addr    = s_q.cnt[CW-2:0];
    assign diff_ready = s_q.ready;

    // R8: position advances by exactly one per accepted sample
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (s_q.cnt == CW'($past(s_q.cnt) + 1'b1)));

    // R8: idle cycles leave the position untouched
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(s_q.cnt));

    // R3: once differences exist they keep being produced
    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready |=> s_q.ready);

endmodule

// File: rtl/sdf_delay_ram.sv
module sdf_delay_ram #(
    parameter int DEPTH = 4,
    parameter int W     = 9,
    parameter int AW    = 2
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0] wr_re,
    input  logic [W-1:0] wr_im,
    output logic [W-1:0] rd_re,
    output logic [W-1:0] rd_im
);
    // Circular store: the same slot is read and rewritten each accepted
    // sample, so every entry ages exactly DEPTH accepted samples.
    logic [2*W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= {wr_im, wr_re};
        end
    end

    assign rd_re = mem_q[addr][W-1:0];
    assign rd_im = mem_q[addr][2*W-1:W];

endmodule

// File: rtl/sdf_scale_sat.sv
module sdf_scale_sat #(
    parameter int WS    = 9,
    parameter int W_OUT = 8,
    parameter int TRUNC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WS-1:0]    x_in,
    output logic [W_OUT-1:0] y_out
);
    localparam logic signed [WS-1:0] MAXV = WS'((64'sd1 <<< (W_OUT - 1)) - 1);
    localparam logic signed [WS-1:0] MINV = WS'(-(64'sd1 <<< (W_OUT - 1)));

    logic signed [WS-1:0] sh;

    always_comb begin
        sh = $signed(x_in) >>> TRUNC;
        if (sh > MAXV) begin
            y_out = MAXV[W_OUT-1:0];
        end else if (sh < MINV) begin
            y_out = MINV[W_OUT-1:0];
        end else begin
            y_out = sh[W_OUT-1:0];
        end
    end

    // R6: clamping never flips the sign of a result
    p_sign_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(x_in) < 0) |-> y_out[W_OUT-1]);

    p_sign_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(x_in) >= 0) |-> !y_out[W_OUT-1]);

endmodule

// File: rtl/sdf_bfly_r2.sv
module sdf_bfly_r2 #(
    parameter int V     = 8,
    parameter int W_IN  = 8,
    parameter int W_OUT = 8,
    parameter int TRUNC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W_IN-1:0]  in_re,
    input  logic [W_IN-1:0]  in_im,
    output logic             out_valid,
    output logic [W_OUT-1:0] out_re,
    output logic [W_OUT-1:0] out_im
);
    import sdf_pkg::*;

    localparam int H  = V / 2;
    localparam int CW = $clog2(V);
    localparam int AW = CW - 1;
    localparam int WS = W_IN + 1;

    logic          phase_hi;
    logic          diff_ready;
    logic [AW-1:0] rd_addr;

    logic [SDF_LANES-1:0][W_IN-1:0]  lane_in;
    logic [SDF_LANES-1:0][WS-1:0]    lane_head;
    logic [SDF_LANES-1:0][WS-1:0]    lane_wr;
    logic [SDF_LANES-1:0][W_OUT-1:0] lane_y;

    assign lane_in[LANE_RE] = in_re;
    assign lane_in[LANE_IM] = in_im;

    sdf_seq_ctrl #(.V(V)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .phase_hi   (phase_hi),
        .rd_addr    (rd_addr),
        .diff_ready (diff_ready)
    );

    sdf_delay_ram #(.DEPTH(H), .W(WS), .AW(AW)) u_store (
        .clk   (clk),
        .wr_en (in_valid),
        .addr  (rd_addr),
        .wr_re (lane_wr[LANE_RE]),
        .wr_im (lane_wr[LANE_IM]),
        .rd_re (lane_head[LANE_RE]),
        .rd_im (lane_head[LANE_IM])
    );

    for (genvar g = 0; g < SDF_LANES; g++) begin : g_lane
        logic signed [WS-1:0] ext;
        logic signed [WS-1:0] head;
        logic signed [WS-1:0] res;
        logic signed [WS-1:0] wr;

        always_comb begin
            ext  = $signed({lane_in[g][W_IN-1], lane_in[g]});
            head = $signed(lane_head[g]);
            if (phase_hi) begin
                res = head + ext;
                wr  = head - ext;
            end else begin
                res = head;
                wr  = ext;
            end
        end

        assign lane_wr[g] = wr;

        sdf_scale_sat #(.WS(WS), .W_OUT(W_OUT), .TRUNC(TRUNC)) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .x_in  (res),
            .y_out (lane_y[g])
        );
    end

    typedef struct packed {
        logic             vld;
        logic [W_OUT-1:0] re;
        logic [W_OUT-1:0] im;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.vld = in_valid && (phase_hi || diff_ready);
        if (o_d.vld) begin
            o_d.re = lane_y[LANE_RE];
            o_d.im = lane_y[LANE_IM];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_re    = o_q.re;
    assign out_im    = o_q.im;

    // R7: every valid output comes from a sample accepted one cycle earlier
    p_valid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R8: an idle input cycle yields a quiet output cycle with held data
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));

    // R9: nothing emerges while the very first half-block is being stored
    p_fill_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !phase_hi && !diff_ready) |=> !out_valid);

    // R2: every accepted sample of a second half produces a sum
    p_sum_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase_hi) |=> out_valid);

endmodule

// File: tb/sdf_bfly_r2_tb.sv
module sdf_bfly_r2_tb;
    import sdf_pkg::*;

    localparam int V     = 8;
    localparam int H     = V / 2;
    localparam int W_IN  = 8;
    localparam int W_OUT = 7;
    localparam int TRUNC = 1;
    localparam int OMAX  = (1 << (W_OUT - 1)) - 1;
    localparam int OMIN  = -(1 << (W_OUT - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [W_IN-1:0]  in_re = '0;
    logic [W_IN-1:0]  in_im = '0;
    logic             out_valid;
    logic [W_OUT-1:0] out_re;
    logic [W_OUT-1:0] out_im;

    always #4 clk = ~clk;

    sdf_bfly_r2 #(.V(V), .W_IN(W_IN), .W_OUT(W_OUT), .TRUNC(TRUNC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    first_in = -1;
    int    first_out = -1;
    bit    done     = 1'b0;

    int    q_re[$];
    int    q_im[$];
    string q_tag[$];

    // Bench model state
    int cur_re[V];
    int cur_im[V];
    int dif_re[H];
    int dif_im[H];
    int pos = 0;
    bit have_dif = 1'b0;

    always @(posedge clk) cyc++;

    function automatic int clampv(input int x);
        int s;
        s = x >>> TRUNC;
        if (s > OMAX) return OMAX;
        if (s < OMIN) return OMIN;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Model of the requirements: sums in second half, differences next block
    task automatic model_push(input int re, input int im, input string tag);
        if (pos < H) begin
            if (have_dif) begin
                q_re.push_back(clampv(dif_re[pos]));
                q_im.push_back(clampv(dif_im[pos]));
                q_tag.push_back("R3");
            end
        end else begin
            q_re.push_back(clampv(cur_re[pos - H] + re));
            q_im.push_back(clampv(cur_im[pos - H] + im));
            q_tag.push_back(tag);
        end
        cur_re[pos] = re;
        cur_im[pos] = im;
        pos++;
        if (pos == V) begin
            for (int n = 0; n < H; n++) begin
                dif_re[n] = cur_re[n] - cur_re[n + H];
                dif_im[n] = cur_im[n] - cur_im[n + H];
            end
            have_dif = 1'b1;
            pos = 0;
        end
    endtask

    task automatic drive(input int re, input int im, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = W_IN'(re);
        in_im    = W_IN'(im);
        if (first_in < 0) first_in = cyc;
        model_push(re, im, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_re    = '1;
        in_im    = '1;
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (first_out < 0) first_out = cyc;
            if (q_re.size() == 0) begin
                check(1'b0, "R7 unexpected valid", 1, 0);
            end else begin
                int er, ei;
                string t;
                er = q_re.pop_front();
                ei = q_im.pop_front();
                t  = q_tag.pop_front();
                check(int'($signed(out_re)) == er, t, int'($signed(out_re)), er);
                check(int'($signed(out_im)) == ei, "R4 imag lane", int'($signed(out_im)), ei);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int held_re, held_im;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_re == '0 && out_im == '0, "R1 data", int'(out_re), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R9/R7: ramp, distinct lanes, continuous
        for (int k = 0; k < V; k++) drive(10 * k - 35, 3 - 7 * k, "R2");
        // R5: negative odd sums exercise flooring
        for (int k = 0; k < V; k++) drive((k < H) ? -k - 1 : -2 * k, (k < H) ? k + 2 : 3 * k, "R5");
        // R6: high saturation
        for (int k = 0; k < V; k++) drive(127 - k, 120 + k, "R6");
        // R6: low saturation
        for (int k = 0; k < V; k++) drive(-128 + k, -100 - k, "R6");
        // R6 via differences: alternating extremes
        for (int k = 0; k < V; k++) drive((k < H) ? 127 : -128, (k < H) ? -128 : 127, "R6");

        // R8: gap after every sample
        for (int k = 0; k < V; k++) begin
            drive(5 * k - 20, 40 - 9 * k, "R8");
            idle();
            #1;
            check(out_valid == 1'b1, "R7 registered output", int'(out_valid), 1);
            held_re = int'(out_re);
            held_im = int'(out_im);
            idle();
            #1;
            check(out_valid == 1'b0, "R8 idle valid", int'(out_valid), 0);
            check(int'(out_re) == held_re && int'(out_im) == held_im, "R8 held data",
                  int'(out_re), held_re);
        end

        // Flush remaining differences
        for (int k = 0; k < V; k++) drive(0, 0, "R2");
        repeat (4) idle();
        #1;
        check(q_re.size() == 0, "R3 all outputs emitted", q_re.size(), 0);
        // R7/R9: first result latency from first sample
        check(first_out - first_in == sdf_stage_delay(V), "R7 stage delay",
              first_out - first_in, sdf_stage_delay(V));
        done = 1'b1;
        report();
    end

endmodule